// File: doc/BRIEF.md
# Phase-Modulated Carrier Synthesizer

The block generates the digital carrier of a polar transmitter. It produces a constant-envelope cosine whose frequency is one of a fixed set of fine-tune channels and whose phase follows the instantaneous phase word delivered by an upstream rectangular-to-polar converter. A phase accumulator advances by a frequency control word on every sample strobe. The channel index selects that control word from a table that is computed when the design is elaborated. The phase word is added to the upper bits of the accumulator, and the sum addresses a cosine table that holds a quarter of a period and folds it by quadrant.

The clock is 26 MHz. The 25 channels sit on a 225 kHz grid from 5 MHz to 10.4 MHz, and 10.4 MHz is 0.4 of the clock rate, the highest frequency allowed. A channel change is picked up at the next strobe. The accumulator is not cleared at that point, so the carrier phase stays continuous. The amplitude envelope is applied further downstream and not here.

Top module: `pmod_synth`

## Requirements
- R1: After reset, and until the first strobe, `acc_o` is 0, `sample_o` is 0 and `sample_vld_o` is 0. The reset input acts asynchronously. Its release reaches the logic through a two-stage synchronizer.
- R2: A clock edge with `stb_i` high adds FCW(c) to `acc_o`, modulo 2^24, and the new value is visible right after that edge. Here c is the value of `chan_i` and FCW(c) = round((5 000 000 + 225 000·c)·2^24 / 26 000 000). The largest control word never exceeds 0.4·2^24.
- R3: A clock edge with `stb_i` low leaves `acc_o` and `sample_o` unchanged, whatever `chan_i` and `pm_i` carry.
- R4: A change of `chan_i` between strobes takes effect at the next strobe. The accumulator continues from its current value and is never reset by that change.
- R5: A `chan_i` value of 25 or more is treated as channel 24.
- R6: Let A be the accumulator value just before the strobe edge and p the signed value of `pm_i`. The sample for that strobe lies within 14 LSB of 2047·cos(2π·(A/2^24 + p/4096)).
- R7: `pm_i` is a signed two's-complement 12-bit word. A value p stands for p·π/2048 rad, so −2048 is −π and +1024 is +π/2. The value adds to the carrier phase as a signed quantity.
- R8: `sample_vld_o` is high for exactly one clock, in the cycle that follows each isolated strobe edge, and `sample_o` then never equals −2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 26 MHz synthesizer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_i | input | 5 | Fine-tune channel index, 0 to 24 |
| pm_i | input | 12 | Signed phase-modulation word in units of π/2048 |
| stb_i | input | 1 | Sample strobe, advances the carrier by one sample |
| acc_o | output | 24 | Current phase accumulator value |
| sample_o | output | 12 | Signed carrier sample |
| sample_vld_o | output | 1 | Marks the cycle in which a new sample is present |

## Verification
Two results are due at different times, and each check waits for its own one.

- **Accumulator:** the new value is present right after the strobe edge. The bench drives each strobe on a falling edge and compares `acc_o` at the following falling edge.
- **Sample:** it passes through the address register and then the lookup register, so it arrives one clock later. The bench compares `sample_o` and the valid flag at the next falling edge against a real-valued cosine of the phase predicted from its own accumulator model. It checks at one more falling edge that the valid flag has dropped and the sample has held.

Idle stretches with changing channel and phase inputs are checked only at the ports.

// File: rtl/pmod_pkg.sv
package pmod_pkg;

  // Rounded control word for one channel of the evenly spaced fine-tune grid.
  function automatic longint unsigned fcw_of(input int unsigned ch,
                                             input longint unsigned lo_hz,
                                             input longint unsigned step_hz,
                                             input longint unsigned clk_hz,
                                             input int unsigned acc_w);
    longint unsigned f_hz;
    f_hz = lo_hz + longint'(ch) * step_hz;
    return ((f_hz << acc_w) + clk_hz / 2) / clk_hz;
  endfunction

  // Quarter-wave cosine point, sampled at half-step offsets so the quadrant folding is exact.
  function automatic int unsigned cos_point(input int unsigned j,
                                            input int unsigned full_aw,
                                            input int unsigned amp);
    real th;
    th = 2.0 * 3.14159265358979 * (real'(j) + 0.5) / real'(longint'(1) << full_aw);
    return int'($rtoi(real'(amp) * $cos(th) + 0.5));
  endfunction

endpackage

// File: rtl/pmod_fcw_rom.sv
module pmod_fcw_rom #(
  parameter int unsigned ACC_W   = 24,
  parameter int unsigned NUM_CH  = 25,
  parameter int unsigned CH_W    = 5,
  parameter longint unsigned CLK_HZ  = 26000000,
  parameter longint unsigned LO_HZ   = 5000000,
  parameter longint unsigned STEP_HZ = 225000
) (
  input  logic [CH_W-1:0]  chan_i,
  output logic [ACC_W-1:0] fcw_o
);
  import pmod_pkg::*;

  localparam logic [CH_W:0] LAST_CH = (CH_W+1)'(NUM_CH - 1);

  logic [ACC_W-1:0] fcw_tab [NUM_CH];
  logic [CH_W:0]    sel;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_tab
    assign fcw_tab[g] = ACC_W'(fcw_of(g, LO_HZ, STEP_HZ, CLK_HZ, ACC_W));
  end

  // Out-of-range index falls back to the highest channel (R5)
  always_comb begin
    sel = {1'b0, chan_i};
    if (sel > LAST_CH) sel = LAST_CH;
    fcw_o = fcw_tab[sel];
  end

endmodule

// File: rtl/pmod_phase_acc.sv
module pmod_phase_acc #(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned PM_W   = 12,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [ACC_W-1:0]  fcw_i,
  input  logic [PM_W-1:0]   pm_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld_o
);
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [PM_W-1:0]   sum;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              vld_q;

  always_comb begin
    // Signed phase word wraps modulo one turn in the top bits.
    sum    = acc_q[ACC_W-1 -: PM_W] + pm_i;
    acc_d  = acc_q;
    addr_d = addr_q;
    if (stb_i) begin
      acc_d  = acc_q + fcw_i;
      addr_d = sum[PM_W-1 -: ADDR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      addr_q <= addr_d;
      vld_q  <= stb_i;
    end
  end

  assign acc_o      = acc_q;
  assign addr_o     = addr_q;
  assign addr_vld_o = vld_q;

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !stb_i |=> $stable(acc_o)); // R3

endmodule

// File: rtl/pmod_cos_lut.sv
module pmod_cos_lut #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned OUT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [OUT_W-1:0]  sample_o,
  output logic              vld_o
);
  import pmod_pkg::*;

  localparam int unsigned Q_W = ADDR_W - 2;
  localparam int unsigned Q_N = 1 << Q_W;
  localparam int unsigned AMP = (1 << (OUT_W - 1)) - 1;

  logic [OUT_W-2:0] q_tab [Q_N];
  logic [1:0]       quad;
  logic [Q_W-1:0]   idx;
  logic [OUT_W-2:0] mag;
  logic             neg;
  logic [OUT_W-1:0] sample_d, sample_q;
  logic             vld_q;

  for (genvar g = 0; g < Q_N; g++) begin : g_q
    assign q_tab[g] = (OUT_W-1)'(cos_point(g, ADDR_W, AMP));
  end

  always_comb begin
    quad = addr_i[ADDR_W-1 -: 2];
    idx  = quad[0] ? ~addr_i[Q_W-1:0] : addr_i[Q_W-1:0];
    mag  = q_tab[idx];
    neg  = quad[1] ^ quad[0];
    sample_d = sample_q;
    if (en_i) sample_d = neg ? -{1'b0, mag} : {1'b0, mag};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      sample_q <= sample_d;
      vld_q    <= en_i;
    end
  end

  assign sample_o = sample_q;
  assign vld_o    = vld_q;

  AST_NO_FULL_NEG: assert property (@(posedge clk) disable iff (!rst_n) vld_o |-> (sample_o != {1'b1, {(OUT_W-1){1'b0}}})); // R8
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !en_i |=> $stable(sample_o)); // R3

endmodule

// File: rtl/pmod_synth.sv
module pmod_synth #(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned PM_W   = 12,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned OUT_W  = 12,
  parameter int unsigned NUM_CH = 25,
  parameter longint unsigned CLK_HZ  = 26000000,
  parameter longint unsigned LO_HZ   = 5000000,
  parameter longint unsigned STEP_HZ = 225000,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [PM_W-1:0]  pm_i,
  input  logic             stb_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [OUT_W-1:0] sample_o,
  output logic             sample_vld_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ACC_W-1:0]  fcw;
  logic [ADDR_W-1:0] addr;
  logic              addr_vld;

  // Asynchronous assertion, synchronous release (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pmod_fcw_rom #(.ACC_W(ACC_W), .NUM_CH(NUM_CH), .CH_W(CH_W), .CLK_HZ(CLK_HZ),
                 .LO_HZ(LO_HZ), .STEP_HZ(STEP_HZ)) u_fcw (
    .chan_i (chan_i),
    .fcw_o  (fcw)
  );

  pmod_phase_acc #(.ACC_W(ACC_W), .PM_W(PM_W), .ADDR_W(ADDR_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .stb_i      (stb_i),
    .fcw_i      (fcw),
    .pm_i       (pm_i),
    .acc_o      (acc_o),
    .addr_o     (addr),
    .addr_vld_o (addr_vld)
  );

  pmod_cos_lut #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_lut (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en_i     (addr_vld),
    .addr_i   (addr),
    .sample_o (sample_o),
    .vld_o    (sample_vld_o)
  );

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_int_n) stb_i |=> acc_o == $past(acc_o) + $past(fcw)); // R2
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n) addr_vld |=> sample_vld_o); // R8
  AST_VLD_SOURCE: assert property (@(posedge clk) disable iff (!rst_int_n) sample_vld_o |-> $past(addr_vld)); // R8

endmodule

// File: tb/pmod_synth_tb_top.sv
module pmod_synth_tb_top;
  localparam int CLK_PERIOD = 38;
  localparam longint MASK = (longint'(1) << 24) - 1;
  localparam real TOL = 14.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  chan;
  logic [11:0] pm;
  logic        stb;
  logic [23:0] acc_o;
  logic [11:0] sample_o;
  logic        sample_vld_o;

  int     n_cmp = 0;
  int     n_bad = 0;
  longint acc_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmod_synth dut_i (
    .clk(clk), .rst_n(rst_n), .chan_i(chan), .pm_i(pm), .stb_i(stb),
    .acc_o(acc_o), .sample_o(sample_o), .sample_vld_o(sample_vld_o)
  );

  function automatic longint fcw_ref(input int c);
    int cc;
    cc = (c > 24) ? 24 : c;
    return ((longint'(5000000 + cc * 225000) << 24) + 13000000) / 26000000;
  endfunction

  function automatic real cos_ref(input longint a, input int p);
    real ph;
    ph = real'(a) / 16777216.0 + real'(p) / 4096.0;
    return 2047.0 * $cos(2.0 * 3.14159265358979 * ph);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One isolated strobe: accumulator after one edge, sample after two, valid low after three.
  task automatic strobe(input int c, input int p, input string req);
    longint a0;
    int     s;
    real    e;
    a0 = acc_m;
    @(negedge clk);
    chan = 5'(c); pm = 12'(p); stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    acc_m = (acc_m + fcw_ref(c)) & MASK;
    check(acc_o == 24'(acc_m), req, longint'(acc_o), acc_m);
    @(negedge clk);
    check(sample_vld_o == 1'b1, "R8", longint'(sample_vld_o), 1);
    s = int'($signed(sample_o));
    e = cos_ref(a0, p);
    check(($itor(s) - e <= TOL) && (e - $itor(s) <= TOL), "R6", longint'(s), longint'($rtoi(e)));
    check(s != -2048, "R8", longint'(s), -2047);
    @(negedge clk);
    check(sample_vld_o == 1'b0, "R8", longint'(sample_vld_o), 0);
    check(int'($signed(sample_o)) == s, "R3", longint'($signed(sample_o)), longint'(s));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] acc_hold;
    logic [11:0] smp_hold;
    void'($urandom(32'd7411));
    rst_n = 1'b0; chan = '0; pm = '0; stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(acc_o == 24'd0, "R1", longint'(acc_o), 0);
    check(sample_o == 12'd0, "R1", longint'(sample_o), 0);
    check(sample_vld_o == 1'b0, "R1", longint'(sample_vld_o), 0);

    // R7 directed phase offsets at known accumulator values
    strobe(0, 0, "R7");
    strobe(3, -2048, "R7");
    strobe(7, 1024, "R7");
    strobe(12, -1024, "R7");
    strobe(24, 2047, "R7");

    // R2 every channel, plus the highest control word bound
    for (int c = 0; c < 25; c++) strobe(c, 0, "R2");
    check(fcw_ref(24) <= 64'd6710886, "R2", fcw_ref(24), 6710886);

    // R5 out-of-range indices
    for (int c = 25; c < 32; c++) strobe(c, 100, "R5");

    // R3 idle cycles with moving inputs
    acc_hold = acc_o;
    smp_hold = sample_o;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chan = 5'($urandom_range(31));
      pm   = 12'($urandom);
    end
    check(acc_o == acc_hold, "R3", longint'(acc_o), longint'(acc_hold));
    check(sample_o == smp_hold, "R3", longint'(sample_o), longint'(smp_hold));
    check(sample_vld_o == 1'b0, "R3", longint'(sample_vld_o), 0);

    // R4 channel hops without accumulator reset, random phase stream
    for (int k = 0; k < 300; k++) begin
      strobe(int'($urandom_range(31)), int'($urandom_range(4095)) - 2048, "R4");
      repeat ($urandom_range(2)) @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule